// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access-Rights Check

This block holds recently used virtual-to-physical page mappings. Each lookup carries a virtual page number, a page offset, an access kind (read or write) and a privilege level (user or kernel). In the same cycle, with no register on the path, the block gives one of four results: a hit with the physical address, a miss that tells the page walker to fetch the mapping, a protection fault, or a request to set the dirty bit before a write may go ahead.

The page walker loads mappings through a refill port. A new mapping takes the slot chosen by a first-in-first-out pointer, or by a pseudo-random pointer when that variant is selected. If the refill's page number is already held, the existing slot is rewritten in place and no slot is used up. Entries carry no address-space tag, so the operating system flushes the whole buffer when it switches processes.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, every entry is invalid, so any lookup reports a miss.
- R2: A permitted lookup that matches a valid entry asserts lk_hit in the same cycle, with lk_paddr equal to {stored PPN, lk_offset}.
- R3: A lookup that matches no valid entry asserts lk_miss only. A hit, fault or dirty request never occurs without a matching valid entry.
- R4: With lk_valid high, exactly one of lk_hit, lk_miss, lk_prot_fault and lk_dirty_upd is high. With lk_valid low, all four are low.
- R5: A read of a matching entry whose read-permission bit is clear raises lk_prot_fault, in both user and kernel mode.
- R6: A write of a matching entry whose write-permission bit is clear raises lk_prot_fault, also in kernel mode.
- R7: A user-mode access (lk_user=1) to an entry whose user-access bit is clear raises lk_prot_fault. A kernel-mode access ignores that bit.
- R8: A permitted write to an entry whose dirty bit is clear raises lk_dirty_upd instead of lk_hit. A read of the same entry hits. A fault takes priority over the dirty request.
- R9: A refill takes effect at the clock edge on which rf_valid is sampled. A lookup in that same cycle sees the old contents.
- R10: A refill whose VPN matches a valid entry rewrites that entry in place and does not move the replacement pointer, so no VPN is ever held twice.
- R11: In FIFO mode, refills of new VPNs fill slots in order, and once the buffer is full each new refill evicts the oldest entry.
- R12: flush invalidates every entry and returns the FIFO pointer to slot 0. A refill in the same cycle as a flush is dropped.
- R13: lk_paddr is zero whenever lk_hit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W (20) | Lookup virtual page number |
| lk_offset | input | OFF_W (12) | Byte offset within the page |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_hit | output | 1 | Translation permitted and ready |
| lk_miss | output | 1 | No valid mapping; page walk needed |
| lk_prot_fault | output | 1 | Access denied by entry rights |
| lk_dirty_upd | output | 1 | Write to a clean page; dirty bit must be set first |
| lk_paddr | output | PPN_W+OFF_W (32) | Physical address on a hit, else zero |
| rf_valid | input | 1 | Refill write strobe |
| rf_vpn | input | VPN_W (20) | Refill virtual page number |
| rf_ppn | input | PPN_W (20) | Refill physical page number |
| rf_read_ok | input | 1 | Refill read permission |
| rf_write_ok | input | 1 | Refill write permission |
| rf_dirty | input | 1 | Refill dirty bit |
| rf_user_ok | input | 1 | Refill user-access permission |

## Verification
All four lookup results are combinational. The bench drives a lookup just after a falling edge and samples the outputs 1 ns later, before the next rising edge, in the same cycle. A refill or flush takes effect at the rising edge that follows the falling edge on which it was driven. Its effect is therefore checked in the next half cycle, and a lookup presented alongside a refill is checked against the old contents. The eviction tests count refills one per cycle, so the exact slot the FIFO pointer reaches is known when each eviction is checked.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef struct packed {
    logic rd;
    logic wr;
    logic dirty;
    logic usr;
  } tlb_perm_t;

  // Access is refused by the entry's rights or by the privilege level.
  function automatic logic perm_denied(tlb_perm_t p, logic is_write, logic is_user);
    logic kind_bad;
    kind_bad = is_write ? !p.wr : !p.rd;
    return kind_bad || (is_user && !p.usr);
  endfunction

  // A permitted write to a clean page must first set the dirty bit.
  function automatic logic dirty_needed(tlb_perm_t p, logic is_write);
    return is_write && !p.dirty;
  endfunction

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  tlb_perm_t          wr_perm,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic [ENTRIES-1:0] lk_match,
  output logic [PPN_W-1:0]   lk_ppn,
  output tlb_perm_t          lk_perm,
  output logic [ENTRIES-1:0] rf_match,
  output logic [IDX_W-1:0]   rf_idx
);

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  tlb_perm_t          perm_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign lk_match[g] = valid_q[g] && (vpn_q[g] == lk_vpn);
    assign rf_match[g] = valid_q[g] && (vpn_q[g] == wr_vpn);

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        valid_q[g] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        valid_q[g] <= 1'b1;
        vpn_q[g]   <= wr_vpn;
        ppn_q[g]   <= wr_ppn;
        perm_q[g]  <= wr_perm;
      end
    end
  end

  // At most one entry matches, so OR-ing the masked fields selects it.
  always_comb begin
    lk_ppn  = '0;
    lk_perm = '0;
    rf_idx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_ppn  = lk_ppn | ppn_q[i];
        lk_perm = lk_perm | perm_q[i];
      end
      if (rf_match[i]) rf_idx = rf_idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int ENTRIES     = 64,
  parameter bit REPL_RANDOM = 1'b0,
  localparam int IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             advance,
  output logic [IDX_W-1:0] victim_idx
);

  if (REPL_RANDOM) begin : g_rand
    logic [15:0] lfsr_q;
    logic [15:0] modv;
    always_ff @(posedge clk) begin
      if (!rst_n) lfsr_q <= 16'hACE1;
      else        lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end
    assign modv       = lfsr_q % 16'(ENTRIES);
    assign victim_idx = modv[IDX_W-1:0];
  end else begin : g_fifo
    logic [IDX_W-1:0] ptr_q;
    always_ff @(posedge clk) begin
      if (!rst_n || flush)              ptr_q <= '0;
      else if (advance) begin
        if (ptr_q == IDX_W'(ENTRIES-1)) ptr_q <= '0;
        else                            ptr_q <= ptr_q + 1'b1;
      end
    end
    assign victim_idx = ptr_q;
  end

endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlb_pkg::*;
(
  input  logic      lk_valid,
  input  logic      match_any,
  input  tlb_perm_t perm,
  input  logic      is_write,
  input  logic      is_user,
  output logic      res_hit,
  output logic      res_miss,
  output logic      res_fault,
  output logic      res_dirty
);

  logic denied;
  logic dirty_req;

  assign denied    = perm_denied(perm, is_write, is_user);
  assign dirty_req = dirty_needed(perm, is_write);

  assign res_miss  = lk_valid && !match_any;
  assign res_fault = lk_valid && match_any && denied;
  assign res_dirty = lk_valid && match_any && !denied && dirty_req;
  assign res_hit   = lk_valid && match_any && !denied && !dirty_req;

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES     = 64,
  parameter int VPN_W       = 20,
  parameter int PPN_W       = 20,
  parameter int OFF_W       = 12,
  parameter bit REPL_RANDOM = 1'b0,
  localparam int IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PA_W       = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [OFF_W-1:0] lk_offset,
  input  logic             lk_write,
  input  logic             lk_user,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_prot_fault,
  output logic             lk_dirty_upd,
  output logic [PA_W-1:0]  lk_paddr,
  input  logic             rf_valid,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PPN_W-1:0] rf_ppn,
  input  logic             rf_read_ok,
  input  logic             rf_write_ok,
  input  logic             rf_dirty,
  input  logic             rf_user_ok
);

  // Named internal events, brought out for the checker.
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] rf_match_vec;
  logic               match_any;
  logic               rf_match_any;
  logic [IDX_W-1:0]   rf_match_idx;
  logic [IDX_W-1:0]   victim_idx;
  logic [IDX_W-1:0]   wr_idx;
  logic               wr_en;
  logic               fifo_adv;
  logic [PPN_W-1:0]   sel_ppn;
  tlb_perm_t          sel_perm;
  tlb_perm_t          rf_perm;

  assign rf_perm      = '{rd: rf_read_ok, wr: rf_write_ok, dirty: rf_dirty, usr: rf_user_ok};
  assign match_any    = |match_vec;
  assign rf_match_any = |rf_match_vec;
  assign wr_en        = rf_valid && !flush;
  assign fifo_adv     = wr_en && !rf_match_any;
  assign wr_idx       = rf_match_any ? rf_match_idx : victim_idx;

  tlb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_vpn   (rf_vpn),
    .wr_ppn   (rf_ppn),
    .wr_perm  (rf_perm),
    .lk_vpn   (lk_vpn),
    .lk_match (match_vec),
    .lk_ppn   (sel_ppn),
    .lk_perm  (sel_perm),
    .rf_match (rf_match_vec),
    .rf_idx   (rf_match_idx)
  );

  tlb_victim_sel #(.ENTRIES(ENTRIES), .REPL_RANDOM(REPL_RANDOM)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .advance    (fifo_adv),
    .victim_idx (victim_idx)
  );

  tlb_perm_check u_perm (
    .lk_valid  (lk_valid),
    .match_any (match_any),
    .perm      (sel_perm),
    .is_write  (lk_write),
    .is_user   (lk_user),
    .res_hit   (lk_hit),
    .res_miss  (lk_miss),
    .res_fault (lk_prot_fault),
    .res_dirty (lk_dirty_upd)
  );

  assign lk_paddr = lk_hit ? {sel_ppn, lk_offset} : '0;

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int ENTRIES     = 64,
  parameter int PA_W        = 32,
  parameter int IDX_W       = 6,
  parameter bit REPL_RANDOM = 1'b0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               lk_valid,
  input logic               lk_hit,
  input logic               lk_miss,
  input logic               lk_prot_fault,
  input logic               lk_dirty_upd,
  input logic [PA_W-1:0]    lk_paddr,
  input logic [ENTRIES-1:0] match_vec,
  input logic               match_any,
  input logic               fifo_adv,
  input logic [IDX_W-1:0]   victim_idx
);

  // R4
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ($countones({lk_hit, lk_miss, lk_prot_fault, lk_dirty_upd}) == 1));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss || lk_prot_fault || lk_dirty_upd));

  // R10
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R3
  needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit || lk_prot_fault || lk_dirty_upd) |-> match_any);

  // R12
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (match_vec == '0));

  // R13
  paddr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == '0));

  if (!REPL_RANDOM) begin : g_fifo_chk
    // R11
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_adv && !flush) |=> $stable(victim_idx));
  end

endmodule

bind tlb_xlate tlb_xlate_chk #(
  .ENTRIES(ENTRIES), .PA_W(PA_W), .IDX_W(IDX_W), .REPL_RANDOM(REPL_RANDOM)
) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_prot_fault(lk_prot_fault),
  .lk_dirty_upd(lk_dirty_upd), .lk_paddr(lk_paddr), .match_vec(match_vec),
  .match_any(match_any), .fifo_adv(fifo_adv), .victim_idx(victim_idx)
);

// File: tb/tlb_xlate_tb_top.sv
`timescale 1ns/1ps
module tlb_xlate_tb_top;

  localparam int ENTRIES = 64;
  localparam int VPN_W   = 20;
  localparam int PPN_W   = 20;
  localparam int OFF_W   = 12;
  localparam int PA_W    = PPN_W + OFF_W;

  localparam int K_MISS  = 0;
  localparam int K_HIT   = 1;
  localparam int K_FAULT = 2;
  localparam int K_DIRTY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic lk_valid = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic [OFF_W-1:0] lk_offset = '0;
  logic lk_write = 1'b0;
  logic lk_user = 1'b0;
  logic lk_hit, lk_miss, lk_prot_fault, lk_dirty_upd;
  logic [PA_W-1:0] lk_paddr;
  logic rf_valid = 1'b0;
  logic [VPN_W-1:0] rf_vpn = '0;
  logic [PPN_W-1:0] rf_ppn = '0;
  logic rf_read_ok = 1'b0, rf_write_ok = 1'b0, rf_dirty = 1'b0, rf_user_ok = 1'b0;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  tlb_xlate #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_offset(lk_offset),
    .lk_write(lk_write), .lk_user(lk_user),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_prot_fault(lk_prot_fault),
    .lk_dirty_upd(lk_dirty_upd), .lk_paddr(lk_paddr),
    .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
    .rf_read_ok(rf_read_ok), .rf_write_ok(rf_write_ok),
    .rf_dirty(rf_dirty), .rf_user_ok(rf_user_ok)
  );

  // Compare the sampled outputs with the expected result kind and address.
  task automatic judge(input int kind, input logic [PPN_W-1:0] ppn, input string req);
    logic [3:0] exp_flags;
    logic [3:0] got_flags;
    logic [PA_W-1:0] exp_pa;
    case (kind)
      K_HIT:   exp_flags = 4'b1000;
      K_MISS:  exp_flags = 4'b0100;
      K_FAULT: exp_flags = 4'b0010;
      K_DIRTY: exp_flags = 4'b0001;
      default: exp_flags = 4'b0000;
    endcase
    exp_pa    = (kind == K_HIT) ? {ppn, lk_offset} : '0;
    got_flags = {lk_hit, lk_miss, lk_prot_fault, lk_dirty_upd};
    total++;
    if (got_flags !== exp_flags || lk_paddr !== exp_pa) begin
      bad++;
      $display("FAIL %s: flags(hit,miss,fault,dirty)=%b paddr=%h expected flags=%b paddr=%h",
               req, got_flags, lk_paddr, exp_flags, exp_pa);
    end
  endtask

  task automatic look(input logic [VPN_W-1:0] vpn, input logic wr, input logic usr,
                      input int kind, input logic [PPN_W-1:0] ppn, input string req);
    @(negedge clk);
    lk_valid  = 1'b1;
    lk_vpn    = vpn;
    lk_offset = vpn[OFF_W-1:0] ^ 12'h5A5;
    lk_write  = wr;
    lk_user   = usr;
    #1;
    judge(kind, ppn, req);
  endtask

  task automatic refill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                        input logic r, input logic w, input logic d, input logic u);
    @(negedge clk);
    lk_valid = 1'b0;
    rf_valid = 1'b1; rf_vpn = vpn; rf_ppn = ppn;
    rf_read_ok = r; rf_write_ok = w; rf_dirty = d; rf_user_ok = u;
    @(negedge clk);
    rf_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    lk_valid = 1'b0;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    look(20'h00000, 1'b0, 1'b0, K_MISS, '0, "R1 empty after reset");
    look(20'hFFFFF, 1'b1, 1'b1, K_MISS, '0, "R3 miss with zero paddr");
  endtask

  task automatic t_basic();
    // R9: refill and lookup in the same cycle; the lookup sees old contents.
    @(negedge clk);
    rf_valid = 1'b1; rf_vpn = 20'h12345; rf_ppn = 20'hABCDE;
    rf_read_ok = 1; rf_write_ok = 1; rf_dirty = 1; rf_user_ok = 1;
    lk_valid = 1'b1; lk_vpn = 20'h12345; lk_offset = 12'h321;
    lk_write = 1'b0; lk_user = 1'b1;
    #1;
    judge(K_MISS, '0, "R9 same-cycle lookup sees old contents");
    @(negedge clk);
    rf_valid = 1'b0;
    #1;
    judge(K_HIT, 20'hABCDE, "R9 refill visible next cycle");
    look(20'h12345, 1'b0, 1'b1, K_HIT, 20'hABCDE, "R2 user read hit");
    look(20'h12345, 1'b1, 1'b0, K_HIT, 20'hABCDE, "R2 kernel write hit");
    look(20'h12346, 1'b0, 1'b0, K_MISS, '0, "R3 neighbouring page misses");
  endtask

  task automatic t_idle();
    @(negedge clk);
    lk_valid = 1'b0; lk_vpn = 20'h12345;
    #1;
    judge(-1, '0, "R4 no result without lk_valid");
  endtask

  task automatic t_perm();
    refill(20'h00A00, 20'h000A0, 1'b0, 1'b1, 1'b1, 1'b1);
    refill(20'h00B00, 20'h000B0, 1'b1, 1'b0, 1'b1, 1'b1);
    refill(20'h00C00, 20'h000C0, 1'b1, 1'b1, 1'b1, 1'b0);
    refill(20'h00D00, 20'h000D0, 1'b1, 1'b1, 1'b0, 1'b1);
    refill(20'h00E00, 20'h000E0, 1'b1, 1'b0, 1'b0, 1'b1);
    look(20'h00A00, 1'b0, 1'b1, K_FAULT, '0, "R5 user read without read right");
    look(20'h00A00, 1'b0, 1'b0, K_FAULT, '0, "R5 kernel read without read right");
    look(20'h00A00, 1'b1, 1'b1, K_HIT, 20'h000A0, "R5 write allowed on write-only page");
    look(20'h00B00, 1'b1, 1'b0, K_FAULT, '0, "R6 kernel write to read-only page");
    look(20'h00B00, 1'b1, 1'b1, K_FAULT, '0, "R6 user write to read-only page");
    look(20'h00C00, 1'b0, 1'b1, K_FAULT, '0, "R7 user read of kernel page");
    look(20'h00C00, 1'b0, 1'b0, K_HIT, 20'h000C0, "R7 kernel read of kernel page");
    look(20'h00C00, 1'b1, 1'b0, K_HIT, 20'h000C0, "R7 kernel write of kernel page");
    look(20'h00D00, 1'b1, 1'b1, K_DIRTY, '0, "R8 write to clean page");
    look(20'h00D00, 1'b0, 1'b1, K_HIT, 20'h000D0, "R8 read of clean page hits");
    look(20'h00E00, 1'b1, 1'b0, K_FAULT, '0, "R8 fault beats dirty request");
  endtask

  task automatic t_flush();
    // R12: flush and refill together; the refill is dropped.
    @(negedge clk);
    lk_valid = 1'b0; flush = 1'b1;
    rf_valid = 1'b1; rf_vpn = 20'h0F000; rf_ppn = 20'h0F0F0;
    rf_read_ok = 1; rf_write_ok = 1; rf_dirty = 1; rf_user_ok = 1;
    @(negedge clk);
    flush = 1'b0; rf_valid = 1'b0;
    look(20'h12345, 1'b0, 1'b0, K_MISS, '0, "R12 flushed entry misses");
    look(20'h00C00, 1'b0, 1'b0, K_MISS, '0, "R12 flushed kernel entry misses");
    look(20'h0F000, 1'b0, 1'b0, K_MISS, '0, "R12 refill during flush dropped");
  endtask

  task automatic t_fifo();
    do_flush();
    for (int i = 0; i < ENTRIES; i++)
      refill(20'h10000 + VPN_W'(i), 20'h20000 + PPN_W'(i), 1'b1, 1'b1, 1'b1, 1'b1);
    look(20'h10000, 1'b0, 1'b0, K_HIT, 20'h20000, "R11 first fill present when full");
    look(20'h10000 + VPN_W'(ENTRIES-1), 1'b0, 1'b0, K_HIT,
         20'h20000 + PPN_W'(ENTRIES-1), "R11 last fill present");
    refill(20'h1F000, 20'h2F000, 1'b1, 1'b1, 1'b1, 1'b1);
    look(20'h10000, 1'b0, 1'b0, K_MISS, '0, "R11 oldest evicted");
    look(20'h10001, 1'b0, 1'b0, K_HIT, 20'h20001, "R11 second oldest kept");
    look(20'h1F000, 1'b0, 1'b0, K_HIT, 20'h2F000, "R11 new entry present");
  endtask

  task automatic t_overwrite();
    do_flush();
    refill(20'h30000, 20'h00111, 1'b1, 1'b1, 1'b1, 1'b1);
    refill(20'h30000, 20'h00222, 1'b1, 1'b1, 1'b1, 1'b1);
    look(20'h30000, 1'b0, 1'b0, K_HIT, 20'h00222, "R10 rewrite in place");
    for (int i = 1; i < ENTRIES; i++)
      refill(20'h40000 + VPN_W'(i), 20'h50000 + PPN_W'(i), 1'b1, 1'b1, 1'b1, 1'b1);
    look(20'h30000, 1'b0, 1'b0, K_HIT, 20'h00222, "R10 rewrite kept one slot");
    refill(20'h4FFFF, 20'h5FFFF, 1'b1, 1'b1, 1'b1, 1'b1);
    look(20'h30000, 1'b0, 1'b0, K_MISS, '0, "R10 pointer unmoved by rewrite");
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_idle();
    t_perm();
    t_flush();
    t_fifo();
    t_overwrite();
    @(negedge clk);
    lk_valid = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule